// File: doc/BRIEF.md
# Clock Management Register Block

This block holds the programmable state of a clock and power manager behind a simple 32-bit register bus. Software enables system clocks and peripheral clocks by writing ones to a set address and disables them by writing ones to a clear address. The accumulated enable state is then read back from a separate status address. The block also stores the main-oscillator word, two PLL words, the master-clock word and four programmable-clock words. It keeps a sticky status word and an interrupt mask, and it drives a single level interrupt.

The three clock-tree words (both PLL words and the master-clock word) cannot be read over the bus. They go out on ports to a separate frequency calculator. That calculator returns one flag, `mck_valid`, and the block copies it into status bit 3 on every effective write. Writing the oscillator word or a PLL word raises that source's ready flag at once. No start-up or lock delay is modelled. A read of the measurement address reports a fixed oscillator frequency count while the oscillator is enabled.

Top module: `clkmgr_regs`

## Requirements
- R1: After reset:
  - system-clock status reads 1.
  - peripheral status, oscillator word, frequency readback, mask and all four programmable words read 0.
  - status reads 0x08 and `irq` is 0.
  - `pll_a_word` and `pll_b_word` are 0x3F00, and `mck_word` is 0.
- R2: A write to 0x00 ORs the written bits into system-clock status, and a write to 0x04 clears them. Both act only on bits 11:7 (mask 0xF80), so bit 0 keeps its reset value. The status is read at 0x08.
- R3: A write to 0x10 sets the written bits in peripheral-clock status, and a write to 0x14 clears them. Bits 1:0 are never affected. The status is read at 0x18.
- R4: Status bits stick until reset; no write clears them.
  - A write to 0x20 stores the oscillator word (read at 0x20) and sets status bit 0.
  - A write to 0x28 stores the PLL A word and sets status bit 1.
  - A write to 0x2C stores the PLL B word and sets status bit 2.
  - A write to 0x30 stores the master-clock word.
- R5: On every write to a writable address, status bit 3 takes the value of `mck_valid`. Writes to any other address leave it unchanged.
- R6: A read of 0x24 returns 0x00010011 when bit 0 of the oscillator word is 1, and 0 otherwise.
- R7: A write to 0x60 ORs the data into the interrupt mask and a write to 0x64 clears the written bits. The mask is read at 0x6C and the status word at 0x68.
- R8: `irq` is 1 exactly when status AND mask is nonzero.
- R9: Reads of 0x00, 0x04, 0x10, 0x14, 0x28, 0x2C, 0x30, 0x60, 0x64 and of unmapped addresses return 0. Writes to unmapped addresses or read-only addresses (0x08, 0x18, 0x24, 0x68, 0x6C) change nothing.
- R10: Read data appears on `rdata` in the cycle after `rd_en`, and is 0 in a cycle that follows no read strobe.
- R11: Addresses 0x40, 0x44, 0x48 and 0x4C each hold an independent 32-bit programmable-clock word that reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 7 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| mck_valid | input | 1 | Master-clock frequency valid flag from the calculator |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| pll_a_word | output | 32 | Stored PLL A word |
| pll_b_word | output | 32 | Stored PLL B word |
| mck_word | output | 32 | Stored master-clock word |

## Verification
The assertions assume that `wr_en` and `rd_en` stay low while reset is held. They also assume that `mck_valid` and the address are stable across the sampling edge of a strobe. The stimulus changes every input only on the falling clock edge and issues one strobe per transaction. It holds `mck_valid` fixed across each write, and moves it between writes to check that status bit 3 follows it only on effective writes.

// File: rtl/clkmgr_regs.sv
module clkmgr_regs #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int NPCK = 4,
  parameter logic [DATA_W-1:0] SYS_MASK = 32'h0000_0F80,
  parameter logic [DATA_W-1:0] PER_MASK = 32'hFFFF_FFFC,
  parameter logic [DATA_W-1:0] PLL_RST = 32'h0000_3F00,
  parameter logic [DATA_W-1:0] FREQ_WORD = 32'h0001_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              mck_valid,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [DATA_W-1:0] pll_a_word,
  output logic [DATA_W-1:0] pll_b_word,
  output logic [DATA_W-1:0] mck_word
);
  localparam logic [ADDR_W-1:0] A_SYS_SET = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_SYS_CLR = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_SYS_ST  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_PER_SET = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_PER_CLR = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_PER_ST  = ADDR_W'(8'h18);
  localparam logic [ADDR_W-1:0] A_OSC     = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_FREQ    = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_PLLA    = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_PLLB    = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_MCK     = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_PCK     = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_IRQ_SET = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] A_IRQ_CLR = ADDR_W'(8'h64);
  localparam logic [ADDR_W-1:0] A_STAT    = ADDR_W'(8'h68);
  localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(8'h6C);
  localparam int PIW = $clog2(NPCK);

  logic [DATA_W-1:0] sys_q, per_q, osc_q, plla_q, pllb_q, mck_q, status_q, mask_q;
  logic [DATA_W-1:0] pck_q [NPCK];
  logic [DATA_W-1:0] rd_mux;

  wire in_pck = (addr >= A_PCK) && (addr < A_PCK + ADDR_W'(4*NPCK)) && (addr[1:0] == 2'b00);
  wire [PIW-1:0] pck_idx = PIW'((addr - A_PCK) >> 2);

  wire w_sys_set = wr_en && addr == A_SYS_SET;
  wire w_sys_clr = wr_en && addr == A_SYS_CLR;
  wire w_per_set = wr_en && addr == A_PER_SET;
  wire w_per_clr = wr_en && addr == A_PER_CLR;
  wire w_osc     = wr_en && addr == A_OSC;
  wire w_plla    = wr_en && addr == A_PLLA;
  wire w_pllb    = wr_en && addr == A_PLLB;
  wire w_mck     = wr_en && addr == A_MCK;
  wire w_irq_set = wr_en && addr == A_IRQ_SET;
  wire w_irq_clr = wr_en && addr == A_IRQ_CLR;
  wire w_pck     = wr_en && in_pck;
  wire w_any = w_sys_set | w_sys_clr | w_per_set | w_per_clr | w_osc | w_plla |
               w_pllb | w_mck | w_irq_set | w_irq_clr | w_pck;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_q    <= DATA_W'(1);
      per_q    <= '0;
      osc_q    <= '0;
      plla_q   <= PLL_RST;
      pllb_q   <= PLL_RST;
      mck_q    <= '0;
      status_q <= DATA_W'(8);
      mask_q   <= '0;
      for (int i = 0; i < NPCK; i++) pck_q[i] <= '0;
    end else begin
      if (w_sys_set) sys_q <= sys_q | (wdata & SYS_MASK);
      if (w_sys_clr) sys_q <= sys_q & ~(wdata & SYS_MASK);
      if (w_per_set) per_q <= per_q | (wdata & PER_MASK);
      if (w_per_clr) per_q <= per_q & ~(wdata & PER_MASK);
      if (w_osc)  osc_q  <= wdata;
      if (w_plla) plla_q <= wdata;
      if (w_pllb) pllb_q <= wdata;
      if (w_mck)  mck_q  <= wdata;
      if (w_pck)  pck_q[pck_idx] <= wdata;
      if (w_irq_set) mask_q <= mask_q | wdata;
      if (w_irq_clr) mask_q <= mask_q & ~wdata;
      if (w_any)
        status_q <= {status_q[DATA_W-1:4], mck_valid,
                     status_q[2:0] | {w_pllb, w_plla, w_osc}};
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_pck) rd_mux = pck_q[pck_idx];
    else begin
      case (addr)
        A_SYS_ST: rd_mux = sys_q;
        A_PER_ST: rd_mux = per_q;
        A_OSC:    rd_mux = osc_q;
        A_FREQ:   rd_mux = osc_q[0] ? FREQ_WORD : '0;
        A_STAT:   rd_mux = status_q;
        A_MASK:   rd_mux = mask_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_en ? rd_mux : '0;
  end

  assign irq = |(status_q & mask_q);
  assign pll_a_word = plla_q;
  assign pll_b_word = pllb_q;
  assign mck_word = mck_q;
endmodule

// File: rtl/clkmgr_regs_chk.sv
module clkmgr_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [6:0]  addr,
  input logic [31:0] wdata,
  input logic        mck_valid,
  input logic [31:0] rdata,
  input logic        irq,
  input logic [31:0] status,
  input logic [31:0] sys_en
);
  assert_sticky_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status[2:0] & $past(status[2:0])) == $past(status[2:0])));

  assert_mck_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 7'h30) |=> (status[3] == $past(mck_valid)));

  assert_sys_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_en & ~32'h0000_0F81) == 32'h0 && sys_en[0]);

  assert_freq_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 7'h24) |=> (rdata == 32'h0 || rdata == 32'h0001_0011));

  assert_wronly_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (addr == 7'h28 || addr == 7'h2C || addr == 7'h30)) |=> (rdata == 32'h0));

  assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 7'h64 && wdata == 32'hFFFF_FFFF) |=> !irq);

  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == 32'h0));
endmodule

bind clkmgr_regs clkmgr_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .mck_valid(mck_valid), .rdata(rdata), .irq(irq),
  .status(status_q), .sys_en(sys_q)
);

// File: tb/sim_clkmgr_regs.sv
module sim_clkmgr_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, mck_valid = 1;
  logic [6:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, pll_a_word, pll_b_word, mck_word;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 0;

  always #2.5 clk = ~clk;

  clkmgr_regs u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .mck_valid(mck_valid), .rdata(rdata), .irq(irq),
    .pll_a_word(pll_a_word), .pll_b_word(pll_b_word), .mck_word(mck_word));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [6:0] a, logic [31:0] exp, string tag);
    @(negedge clk); rd_en = 1; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0;
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R10 unexpected read data", 32'h1, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 pll_a", pll_a_word, 32'h3F00);
    check("R1 pll_b", pll_b_word, 32'h3F00);
    check("R1 mck", mck_word, 32'h0);
    rd(7'h08, 32'h1, "R1 sys status");
    rd(7'h18, 32'h0, "R1 per status");
    rd(7'h20, 32'h0, "R1 osc");
    rd(7'h24, 32'h0, "R1 freq");
    rd(7'h68, 32'h8, "R1 status");
    rd(7'h6C, 32'h0, "R1 mask");
    for (int i = 0; i < 4; i++) rd(7'h40 + 7'(4*i), 32'h0, "R1 pck");
    // R2 system clock set/clear
    wr(7'h00, 32'hFFFF_FFFF); rd(7'h08, 32'hF81, "R2 set");
    wr(7'h04, 32'h0000_0180); rd(7'h08, 32'hE01, "R2 clear part");
    wr(7'h04, 32'hFFFF_FFFF); rd(7'h08, 32'h1, "R2 clear all");
    rd(7'h00, 32'h0, "R9 read set addr");
    // R3 peripheral clock
    wr(7'h10, 32'hFFFF_FFFF); rd(7'h18, 32'hFFFF_FFFC, "R3 set");
    wr(7'h14, 32'h0000_F00F); rd(7'h18, 32'hFFFF_0FF0, "R3 clear");
    // R4/R5/R6 oscillator
    mck_valid = 0;
    wr(7'h20, 32'h1);
    rd(7'h68, 32'h1, "R4 R5 osc ready, mck cleared");
    rd(7'h24, 32'h0001_0011, "R6 freq on");
    rd(7'h20, 32'h1, "R4 osc word");
    wr(7'h28, 32'h0012_3456);
    check("R4 pll_a word", pll_a_word, 32'h0012_3456);
    rd(7'h28, 32'h0, "R9 pll_a unreadable");
    wr(7'h2C, 32'h0000_ABCD);
    check("R4 pll_b word", pll_b_word, 32'h0000_ABCD);
    rd(7'h68, 32'h7, "R4 lock flags");
    mck_valid = 1;
    wr(7'h30, 32'h5);
    check("R4 mck word", mck_word, 32'h5);
    rd(7'h30, 32'h0, "R9 mck unreadable");
    rd(7'h68, 32'hF, "R5 mck set");
    wr(7'h20, 32'h0);
    rd(7'h24, 32'h0, "R6 freq off");
    rd(7'h68, 32'hF, "R4 sticky");
    // R5/R9 ineffective writes
    mck_valid = 0;
    wr(7'h50, 32'hFFFF_FFFF);
    wr(7'h68, 32'h0);
    wr(7'h24, 32'hFFFF_FFFF);
    rd(7'h68, 32'hF, "R5 R9 no-effect writes");
    rd(7'h50, 32'h0, "R9 unmapped read");
    rd(7'h24, 32'h0, "R9 freq write ignored");
    // R11 programmable words
    wr(7'h40, 32'h11); wr(7'h44, 32'h22); wr(7'h48, 32'h33); wr(7'h4C, 32'h44);
    rd(7'h40, 32'h11, "R11 pck0");
    rd(7'h44, 32'h22, "R11 pck1");
    rd(7'h48, 32'h33, "R11 pck2");
    rd(7'h4C, 32'h44, "R11 pck3");
    rd(7'h68, 32'h7, "R5 pck write clears mck");
    // R7/R8 interrupt
    wr(7'h60, 32'h8);
    check("R8 masked bit low", {31'b0, irq}, 32'h0);
    rd(7'h6C, 32'h8, "R7 mask set");
    mck_valid = 1;
    wr(7'h60, 32'h0);
    check("R8 irq high", {31'b0, irq}, 32'h1);
    wr(7'h64, 32'h8);
    check("R7 R8 mask clear", {31'b0, irq}, 32'h0);
    wr(7'h60, 32'h2);
    check("R8 lock irq", {31'b0, irq}, 32'h1);
    rd(7'h6C, 32'h2, "R7 mask");
    wr(7'h64, 32'hFFFF_FFFF);
    check("R8 all cleared", {31'b0, irq}, 32'h0);
    // R10 idle read data
    @(negedge clk); @(negedge clk);
    check("R10 idle rdata", rdata, 32'h0);
    repeat (3) @(negedge clk);
    check("R10 queue drained", 32'(exp_q.size()), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule